// File: doc/BRIEF.md
# Bus-Mapped SPI Master

This block is a serial peripheral interface master that software drives over a 32-bit single-cycle bus. Software places up to 128 transmit bits in four data words and sets up the clock divider and the slave-select mask. It then writes the control word with the character length, the bit order and the SCLK edges for driving MOSI and sampling MISO, and with the start bit set. The block runs the serial clock and shifts the data out. Each received bit is stored in the position its transmitted bit came from, so the received character ends up right-aligned in the data words.

The start bit reads back as a busy flag and drops by itself after the last SCLK period. When the automatic select mode is on, the chosen select lines go low only for the length of the transfer. When interrupts are enabled, an interrupt line rises at completion and stays high until the next bus access to the block.

Top module: `spi_bus_master`

## Requirements
- R1: After reset, all registers read as zero. `sclk_o` and `mosi_o` are low, `ss_n_o` is all ones and `irq_o` is low.
- R2: Every bus access (`cyc_i` and `stb_i` high) gets a one-cycle `ack_o` in the next cycle, with read data valid in the same cycle as `ack_o`. Word index 0 to 3 selects a data word (index 0 is bits 31:0 of the 128-bit store). Index 4 is control, index 5 is the divider and index 6 is the select mask. Writes to these registers read back unchanged.
- R3: Control bit 8 starts a transfer when written as 1. It reads as 1 while the transfer runs and returns to 0 by itself. A transfer has exactly L rising SCLK edges, where L is control bits 6:0.
- R4: SCLK is low whenever no transfer runs. Each SCLK half period lasts divider+1 clock cycles, so SCLK = clk / (2·(divider+1)).
- R5: With control bit 11 at 0 (MSB first), bit k of the serial stream comes from store position L-1-k.
- R6: With control bit 11 at 1 (LSB first), bit k of the serial stream comes from store position k.
- R7: With control bit 10 at 1, MOSI changes on falling SCLK edges and the first bit is present before the first rising edge. With bit 10 at 0, MOSI changes on rising edges.
- R8: With control bit 9 at 1, MISO is sampled on falling SCLK edges, otherwise on rising edges. Sampled bit k goes to the store position that bit k was sent from, so the other store bits keep their values.
- R9: A length field of 0 means a 128-bit transfer that uses all four data words.
- R10: With control bit 13 at 1, `ss_n_o` is the inverted mask while busy and all ones otherwise. With bit 13 at 0, `ss_n_o` is always the inverted mask.
- R11: While busy, writes to the data words, the control word, the divider and the mask are ignored.
- R12: With control bit 12 at 1, `irq_o` rises when a transfer completes. Any bus access clears it. With bit 12 at 0, `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 3 | Word index (byte offset / 4) |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack |
| ack_o | output | 1 | One-cycle access acknowledge |
| irq_o | output | 1 | Completion interrupt |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | SS_W | Active-low slave selects |

## Verification
The acknowledge properties assume that a master holds `cyc_i` and `stb_i` only until it sees `ack_o`. The bench drops the strobe on the cycle after each acknowledge. The interrupt-clear property assumes completion and bus accesses can coincide only while busy, which follows from the busy flag. The bench's slave model changes MISO only on the SCLK edge opposite to the one the master samples on, so every sampled value is stable for a full half period. Writes during a transfer appear in exactly one directed scenario, which checks that they are ignored.

// File: rtl/spi_bus_master.sv
module spi_bus_master #(
  parameter int SS_W  = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [2:0]       adr_i,
  input  logic [31:0]      dat_i,
  output logic [31:0]      dat_o,
  output logic             ack_o,
  output logic             irq_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [SS_W-1:0]  ss_n_o
);
  localparam int STORE_W = 128;

  logic [STORE_W-1:0] dat_q;
  logic [DIV_W-1:0]   div_q, cnt;
  logic [SS_W-1:0]    ss;
  logic [6:0]         len;
  logic               ass, ie, lsb, txneg, rxneg, busy;
  logic [7:0]         tx_k, rx_k;

  wire [7:0] nbits  = (len == 7'd0) ? 8'd128 : {1'b0, len};
  wire       acc    = cyc_i & stb_i & ~ack_o;
  wire       wr     = acc & we_i & ~busy;
  wire       tick   = busy & (cnt == '0);
  wire       rise   = tick & ~sclk_o;
  wire       fall   = tick & sclk_o;
  wire       done   = fall & ((rx_k + {7'd0, rxneg}) == nbits);
  wire [6:0] tx_pos = lsb ? tx_k[6:0] : len - 7'd1 - tx_k[6:0];
  wire [6:0] rx_pos = lsb ? rx_k[6:0] : len - 7'd1 - rx_k[6:0];
  wire [6:0] go_pos = dat_i[11] ? 7'd0 : dat_i[6:0] - 7'd1;
  wire       tx_ev  = (rise & ~txneg) | (fall & txneg & (tx_k != nbits));
  wire       rx_ev  = (rise & ~rxneg) | (fall & rxneg);

  assign ss_n_o = ~((ass & ~busy) ? '0 : ss);

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;  div_q <= '0;  cnt <= '0;  ss <= '0;  len <= '0;
      ass <= 1'b0;  ie <= 1'b0;  lsb <= 1'b0;  txneg <= 1'b0;  rxneg <= 1'b0;
      busy <= 1'b0;  tx_k <= '0;  rx_k <= '0;
      dat_o <= '0;  ack_o <= 1'b0;  irq_o <= 1'b0;  sclk_o <= 1'b0;  mosi_o <= 1'b0;
    end else begin
      ack_o <= acc;
      if (acc) begin
        case (adr_i)
          3'd0, 3'd1, 3'd2, 3'd3: dat_o <= dat_q[{adr_i[1:0], 5'd0} +: 32];
          3'd4: dat_o <= {18'd0, ass, ie, lsb, txneg, rxneg, busy, 1'b0, len};
          3'd5: dat_o <= 32'(div_q);
          3'd6: dat_o <= 32'(ss);
          default: dat_o <= '0;
        endcase
      end
      if (wr) begin
        case (adr_i)
          3'd0, 3'd1, 3'd2, 3'd3: dat_q[{adr_i[1:0], 5'd0} +: 32] <= dat_i;
          3'd4: begin
            {ass, ie, lsb, txneg, rxneg} <= dat_i[13:9];
            len <= dat_i[6:0];
            if (dat_i[8]) begin
              busy <= 1'b1;
              cnt  <= div_q;
              rx_k <= '0;
              tx_k <= '0;
              if (dat_i[10]) begin
                mosi_o <= dat_q[go_pos];
                tx_k   <= 8'd1;
              end
            end
          end
          3'd5: div_q <= dat_i[DIV_W-1:0];
          3'd6: ss <= dat_i[SS_W-1:0];
          default: ;
        endcase
      end
      if (busy) begin
        cnt <= tick ? div_q : cnt - 1'b1;
        if (tick) sclk_o <= ~sclk_o;
        if (tx_ev) begin
          mosi_o <= dat_q[tx_pos];
          tx_k   <= tx_k + 8'd1;
        end
        if (rx_ev) begin
          dat_q[rx_pos] <= miso_i;
          rx_k          <= rx_k + 8'd1;
        end
        if (done) busy <= 1'b0;
      end
      if (done && ie) irq_o <= 1'b1;
      else if (cyc_i && stb_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_bus_master_chk.sv
module spi_bus_master_chk #(
  parameter int SS_W  = 16,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_i,
  input logic             stb_i,
  input logic             we_i,
  input logic [2:0]       adr_i,
  input logic             ack_o,
  input logic             irq_o,
  input logic             sclk_o,
  input logic [SS_W-1:0]  ss_n_o,
  input logic             busy,
  input logic             ass,
  input logic [DIV_W-1:0] div_q
);
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc_i && stb_i && !ack_o) |=> ack_o);

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk_o);

  assert_sclk_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_o) |-> $past(busy));

  assert_ss_release_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && ass) |-> (&ss_n_o));

  assert_div_locked_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc_i && stb_i && we_i && adr_i == 3'd5) |=> $stable(div_q));

  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (cyc_i && stb_i && !busy) |=> !irq_o);

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $fell(busy));
endmodule

bind spi_bus_master spi_bus_master_chk #(.SS_W(SS_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i),
  .ack_o(ack_o), .irq_o(irq_o), .sclk_o(sclk_o), .ss_n_o(ss_n_o),
  .busy(busy), .ass(ass), .div_q(div_q)
);

// File: tb/spi_bus_master_tb.sv
module spi_bus_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
  logic [2:0]  adr_i = '0;
  logic [31:0] dat_i = '0;
  logic [31:0] dat_o;
  logic        ack_o, irq_o, sclk_o, mosi_o;
  logic        miso_i = 1'b0;
  logic [15:0] ss_n_o;

  int checks = 0, errors = 0, cyc_n = 0;

  spi_bus_master u_dut (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i),
    .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o), .irq_o(irq_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc_n++;

  // slave model
  bit           m_txneg, m_rxneg;
  logic [127:0] pat, rec;
  int           rcnt, mcnt, nrise, rise_t0, rise_t1;
  logic [15:0]  ss_seen;

  always @(posedge sclk_o) begin
    nrise++;
    if (nrise == 1) begin rise_t0 = cyc_n; ss_seen = ss_n_o; end
    if (nrise == 2) rise_t1 = cyc_n;
    if (m_txneg) begin if (rcnt < 128) rec[rcnt] = mosi_o; rcnt++; end
    if (m_rxneg) begin if (mcnt < 128) miso_i = pat[mcnt]; mcnt++; end
  end
  always @(negedge sclk_o) begin
    if (!m_txneg) begin if (rcnt < 128) rec[rcnt] = mosi_o; rcnt++; end
    if (!m_rxneg) begin mcnt++; if (mcnt < 128) miso_i = pat[mcnt]; end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic last_ack;
  task automatic bus(input bit wr, input logic [2:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc_i = 1'b1; stb_i = 1'b1; we_i = wr; adr_i = a; dat_i = d;
    @(posedge clk);
    @(negedge clk);
    last_ack = ack_o;
    q = dat_o;
    cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr32(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rd32(input logic [2:0] a, output logic [31:0] q);
    bus(1'b0, a, '0, q);
  endtask

  function automatic logic [31:0] mk_ctrl(bit a, bit i, bit l, bit t, bit r, bit g, logic [6:0] n);
    return {18'd0, a, i, l, t, r, g, 1'b0, n};
  endfunction

  function automatic int nb_of(logic [6:0] n);
    return (n == 0) ? 128 : int'(n);
  endfunction

  function automatic logic [127:0] exp_mosi(logic [127:0] tx, int nb, bit l);
    logic [127:0] r = '0;
    for (int k = 0; k < nb; k++) r[k] = l ? tx[k] : tx[nb-1-k];
    return r;
  endfunction

  function automatic logic [127:0] exp_store(logic [127:0] tx, logic [127:0] p, int nb, bit l);
    logic [127:0] r = tx;
    for (int k = 0; k < nb; k++) r[l ? k : nb-1-k] = p[k];
    return r;
  endfunction

  task automatic wait_idle();
    logic [31:0] q;
    for (int i = 0; i < 5000; i++) begin
      rd32(3'd4, q);
      if (!q[8]) return;
    end
    chk(1'b0, "R3 busy never cleared", 1, 0);
  endtask

  task automatic start(input logic [6:0] n, input bit l, input bit t, input bit r, input bit a,
                       input bit i, input logic [15:0] dv, input logic [15:0] mask,
                       input logic [127:0] tx, input logic [127:0] p);
    wr32(3'd5, {16'd0, dv});
    wr32(3'd6, {16'd0, mask});
    for (int w = 0; w < 4; w++) wr32(3'(w), tx[32*w +: 32]);
    m_txneg = t; m_rxneg = r; pat = p; rec = '0;
    rcnt = 0; mcnt = 0; nrise = 0;
    miso_i = r ? 1'b0 : p[0];
    wr32(3'd4, mk_ctrl(a, i, l, t, r, 1'b1, n));
  endtask

  task automatic verify(input string req, input logic [6:0] n, input bit l,
                        input logic [127:0] tx, input logic [127:0] p);
    logic [127:0] got;
    logic [31:0]  q;
    int nb = nb_of(n);
    logic [127:0] em = exp_mosi(tx, nb, l);
    logic [127:0] mask = (nb == 128) ? '1 : ((128'd1 << nb) - 1);
    for (int w = 0; w < 4; w++) begin rd32(3'(w), q); got[32*w +: 32] = q; end
    chk((rec & mask) == em, {req, " mosi stream"}, rec & mask, em);
    chk(got == exp_store(tx, p, nb, l), {req, " received store"}, got, exp_store(tx, p, nb, l));
    chk(nrise == nb, "R3 rising edge count", nrise, nb);
  endtask

  task automatic t_reset();
    logic [31:0] q;
    chk(sclk_o == 0 && mosi_o == 0, "R1 serial pins idle", {sclk_o, mosi_o}, 0);
    chk(ss_n_o == 16'hFFFF, "R1 selects released", ss_n_o, 16'hFFFF);
    chk(irq_o == 0, "R1 irq low", irq_o, 0);
    rd32(3'd4, q); chk(q == 0, "R1 control zero", q, 0);
    rd32(3'd5, q); chk(q == 0, "R1 divider zero", q, 0);
    rd32(3'd0, q); chk(q == 0, "R1 word0 zero", q, 0);
  endtask

  task automatic t_regs();
    logic [31:0] q;
    wr32(3'd5, 32'h0000_0003);
    chk(last_ack == 1, "R2 ack after write", last_ack, 1);
    @(negedge clk);
    chk(ack_o == 0, "R2 ack single cycle", ack_o, 0);
    rd32(3'd5, q); chk(q == 32'h3, "R2 divider readback", q, 32'h3);
    wr32(3'd6, 32'h0000_00A5);
    rd32(3'd6, q); chk(q == 32'hA5, "R2 mask readback", q, 32'hA5);
    wr32(3'd2, 32'hCAFE_F00D);
    rd32(3'd2, q); chk(q == 32'hCAFE_F00D, "R2 word2 readback", q, 32'hCAFE_F00D);
    wr32(3'd4, mk_ctrl(0, 1, 1, 0, 1, 0, 7'd20));
    rd32(3'd4, q); chk(q == mk_ctrl(0, 1, 1, 0, 1, 0, 7'd20), "R2 control readback", q, mk_ctrl(0, 1, 1, 0, 1, 0, 7'd20));
  endtask

  task automatic t_msb_8();
    logic [127:0] tx = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32B6;
    logic [127:0] p  = 128'h0000_0000_0000_0000_0000_0000_0000_005C;
    start(7'd8, 0, 1, 0, 1, 0, 16'd1, 16'h0001, tx, p);
    wait_idle();
    verify("R5 R7 R8 msb/txneg", 7'd8, 0, tx, p);
  endtask

  task automatic t_lsb_16();
    logic [127:0] tx = 128'h1111_2222_3333_4444_5555_6666_7777_C3A5;
    logic [127:0] p  = 128'h0000_0000_0000_0000_0000_0000_0000_9E61;
    start(7'd16, 1, 0, 1, 1, 0, 16'd2, 16'h0002, tx, p);
    wait_idle();
    verify("R6 R7 R8 lsb/rxneg", 7'd16, 1, tx, p);
  endtask

  task automatic t_both_neg_24();
    logic [127:0] tx = 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_12D4_5E7A;
    logic [127:0] p  = 128'h0000_0000_0000_0000_0000_0000_0093_0F3C;
    start(7'd24, 0, 1, 1, 1, 0, 16'd0, 16'h0004, tx, p);
    wait_idle();
    verify("R7 R8 both falling", 7'd24, 0, tx, p);
  endtask

  task automatic t_both_pos_32();
    logic [127:0] tx = 128'h9999_8888_7777_6666_5555_4444_F00D_BEEF;
    logic [127:0] p  = 128'h0000_0000_0000_0000_0000_0000_1357_9BDF;
    start(7'd32, 1, 0, 0, 1, 0, 16'd1, 16'h0008, tx, p);
    wait_idle();
    verify("R6 R7 R8 both rising", 7'd32, 1, tx, p);
  endtask

  task automatic t_full_128();
    logic [127:0] tx = 128'h8F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    logic [127:0] p  = 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321;
    start(7'd0, 0, 1, 0, 1, 0, 16'd0, 16'h0010, tx, p);
    wait_idle();
    verify("R9 R5 length zero", 7'd0, 0, tx, p);
  endtask

  task automatic t_timing_ss();
    logic [127:0] tx = 128'h5A;
    logic [127:0] p  = 128'hC3;
    start(7'd8, 0, 0, 1, 1, 0, 16'd2, 16'h8421, tx, p);
    wait_idle();
    chk(rise_t1 - rise_t0 == 6, "R4 sclk period", rise_t1 - rise_t0, 6);
    chk(ss_seen == 16'h7BDE, "R10 auto select during transfer", ss_seen, 16'h7BDE);
    chk(ss_n_o == 16'hFFFF, "R10 auto select released", ss_n_o, 16'hFFFF);
    chk(sclk_o == 0, "R4 sclk idle low", sclk_o, 0);
    verify("R4 timing run", 7'd8, 0, tx, p);
    start(7'd8, 0, 0, 1, 0, 0, 16'd0, 16'h0300, tx, p);
    wait_idle();
    chk(ss_n_o == 16'hFCFF, "R10 manual select held", ss_n_o, 16'hFCFF);
  endtask

  task automatic t_busy_lock();
    logic [31:0] q;
    logic [127:0] tx = 128'h0000_0000_0000_0000_7654_3210_DEAD_BEEF;
    logic [127:0] p  = 128'hA5A5_0F0F;
    start(7'd32, 0, 1, 0, 1, 0, 16'd7, 16'h0020, tx, p);
    wr32(3'd5, 32'h55);
    wr32(3'd6, 32'h1);
    wr32(3'd1, 32'h1234_5678);
    wr32(3'd0, 32'h0);
    wr32(3'd4, mk_ctrl(0, 1, 1, 0, 0, 0, 7'd4));
    rd32(3'd4, q);
    chk(q == mk_ctrl(1, 0, 0, 1, 0, 1, 7'd32), "R3 R11 busy control readback", q, mk_ctrl(1, 0, 0, 1, 0, 1, 7'd32));
    wait_idle();
    rd32(3'd5, q); chk(q == 7, "R11 divider write ignored", q, 7);
    rd32(3'd6, q); chk(q == 32'h20, "R11 mask write ignored", q, 32'h20);
    verify("R11 data writes ignored", 7'd32, 0, tx, p);
  endtask

  task automatic t_irq();
    logic [31:0] q;
    logic [127:0] tx = 128'h3C;
    logic [127:0] p  = 128'h81;
    start(7'd8, 0, 1, 0, 1, 1, 16'd1, 16'h0001, tx, p);
    for (int i = 0; i < 400 && !irq_o; i++) @(negedge clk);
    chk(irq_o == 1, "R12 irq on completion", irq_o, 1);
    rd32(3'd4, q);
    chk(q[8] == 0, "R3 busy clear at irq", q[8], 0);
    @(negedge clk);
    chk(irq_o == 0, "R12 irq cleared by access", irq_o, 0);
    start(7'd8, 0, 1, 0, 1, 0, 16'd1, 16'h0001, tx, p);
    repeat (60) @(negedge clk);
    chk(irq_o == 0, "R12 no irq when disabled", irq_o, 0);
    rd32(3'd4, q);
    chk(q[8] == 0, "R3 busy clear after run", q[8], 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_msb_8();
    t_lsb_16();
    t_both_neg_24();
    t_both_pos_32();
    t_full_128();
    t_timing_ss();
    t_busy_lock();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule